// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two buses, A and B, through a non-inverting data path of parameterised width (default 18 bits). Each direction has its own control set, its own clock and one storage element per bit. That storage can act in three ways:
- as a transparent latch, where the output follows the input;
- as an edge-triggered register, where capture is gated by an active-low clock enable;
- as a hold, where the stored word stays on the output.

An active-low output enable per direction switches that direction's drivers off.

The block does not use internal tristates. Each direction has a data-out vector and a single drive-enable bit, so pad cells can be added at the chip top. When latch-enable is high, the storage register still loads the input on every edge of its direction clock. When latch-enable falls, the word present at the last edge is kept. Stored data has no asynchronous reset. A synchronous active-low reset clears the stored data on the next edge of each direction clock.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: The width is the parameter WIDTH, 18 by default. Data passes unchanged, with no inversion, in both directions: bit i of the source bus appears on bit i of the destination.
- R2: When `oe_ab_n` is 1, `b_oe` is 0 whatever the other A-to-B controls are. In the same way, `oe_ba_n` at 1 forces `a_oe` to 0. When an enable input is 0, the matching drive bit is 1.
- R3: When `le_ab` is 1, `b_out` equals `a_in` combinationally, with no clock edge needed.
- R4: When `le_ab` is 0 and `ce_ab_n` is 0, a rising `clk_ab` edge stores `a_in`, and `b_out` shows the stored word after that edge.
- R5: When `le_ab` is 0 and `clk_ab` has no edges, `b_out` keeps the stored word even if `a_in` and `ce_ab_n` change.
- R6: When `le_ab` is 0 and `ce_ab_n` is 1, rising `clk_ab` edges are ignored and `b_out` does not change.
- R7: While `le_ab` is 1, each rising `clk_ab` edge loads `a_in` into storage, whatever `ce_ab_n` is. After `le_ab` falls, `b_out` shows the word loaded at the last edge.
- R8: When `rst_n` is 0 at a rising edge of a direction clock, that direction's stored word becomes 0.
- R9: The B-to-A path (`b_in`, `clk_ba`, `le_ba`, `ce_ba_n`, `oe_ba_n` to `a_out`, `a_oe`) behaves as in R3 to R8. It is independent of the A-to-B storage and controls.
- R10: `a_oe` and `b_oe` both at 1 at the same time is bus contention, and the checker reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | A-to-B storage clock |
| clk_ba | input | 1 | B-to-A storage clock |
| rst_n | input | 1 | Synchronous active-low clear of stored data |
| a_in | input | WIDTH | Data received from bus A |
| b_in | input | WIDTH | Data received from bus B |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| ce_ab_n | input | 1 | A-to-B clock enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| ce_ba_n | input | 1 | B-to-A clock enable, active low |
| b_out | output | WIDTH | Data to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |
| a_out | output | WIDTH | Data to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |

## Verification
The checker watches the following on every edge of each direction clock:
- a clock-enabled capture shows up on the output at the next edge;
- a clock-enable-high edge leaves the output unchanged;
- a transparent edge leaves the tracked word on the output;
- the two drive enables are never on together.

Some behaviour can only be shown by the bench's scenarios:
- the output following its input with no clock edge at all;
- stored words surviving a stopped clock;
- the reset value;
- one direction's storage staying untouched while the other direction is exercised.

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             oe_ab_n,
  input  logic             le_ab,
  input  logic             ce_ab_n,
  input  logic             oe_ba_n,
  input  logic             le_ba,
  input  logic             ce_ba_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe
);

  logic [WIDTH-1:0] hold_ab;
  logic [WIDTH-1:0] hold_ba;

  // transparent mode keeps loading so a falling latch-enable leaves the last tracked word
  always_ff @(posedge clk_ab) begin
    if (!rst_n)                hold_ab <= '0;
    else if (le_ab || !ce_ab_n) hold_ab <= a_in;
  end

  always_ff @(posedge clk_ba) begin
    if (!rst_n)                hold_ba <= '0;
    else if (le_ba || !ce_ba_n) hold_ba <= b_in;
  end

  assign b_out = le_ab ? a_in : hold_ab;
  assign a_out = le_ba ? b_in : hold_ba;
  assign b_oe  = ~oe_ab_n;
  assign a_oe  = ~oe_ba_n;

endmodule

// File: rtl/bidir_latch_xcvr_chk.sv
module bidir_latch_xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             le_ab,
  input logic             ce_ab_n,
  input logic             le_ba,
  input logic             ce_ba_n,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe
);

  assert_capture_ab_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!le_ab && !ce_ab_n) |=> (le_ab || b_out == $past(a_in)));

  assert_ce_hold_ab_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!le_ab && ce_ab_n) |=> (le_ab || b_out == $past(b_out)));

  assert_track_ab_R7: assert property (@(posedge clk_ab) disable iff (!rst_n)
    le_ab |=> (le_ab || b_out == $past(a_in)));

  assert_capture_ba_R9: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!le_ba && !ce_ba_n) |=> (le_ba || a_out == $past(b_in)));

  assert_ce_hold_ba_R9: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!le_ba && ce_ba_n) |=> (le_ba || a_out == $past(a_out)));

  assert_track_ba_R9: assert property (@(posedge clk_ba) disable iff (!rst_n)
    le_ba |=> (le_ba || a_out == $past(b_in)));

  assert_no_contention_ab_R10: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !(a_oe && b_oe));

  assert_no_contention_ba_R10: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !(a_oe && b_oe));

endmodule

bind bidir_latch_xcvr bidir_latch_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
  .a_in(a_in), .b_in(b_in),
  .le_ab(le_ab), .ce_ab_n(ce_ab_n), .le_ba(le_ba), .ce_ba_n(ce_ba_n),
  .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
);

// File: tb/test_bidir_latch_xcvr.sv
`timescale 1ns/1ps
module test_bidir_latch_xcvr;
  localparam int W = 18;

  typedef struct {
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;
    string        req;
  } exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic run_ab = 1'b1, run_ba = 1'b1;
  logic clk_ab, clk_ba;
  assign clk_ab = clk & run_ab;
  assign clk_ba = clk & run_ba;

  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic oe_ab_n = 1'b0, le_ab = 1'b0, ce_ab_n = 1'b1;
  logic oe_ba_n = 1'b1, le_ba = 1'b0, ce_ba_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic b_oe, a_oe;

  bidir_latch_xcvr #(.WIDTH(W)) i_bidir_latch_xcvr (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .a_in(a_in), .b_in(b_in),
    .oe_ab_n(oe_ab_n), .le_ab(le_ab), .ce_ab_n(ce_ab_n),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .ce_ba_n(ce_ba_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
  );

  exp_t q[$];
  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] m_ab = 'x, m_ba = 'x;

  task automatic tick(input string req);
    exp_t e;
    if (run_ab) begin
      if (!rst_n) m_ab = '0;
      else if (le_ab || !ce_ab_n) m_ab = a_in;
    end
    if (run_ba) begin
      if (!rst_n) m_ba = '0;
      else if (le_ba || !ce_ba_n) m_ba = b_in;
    end
    e.b_oe  = !oe_ab_n;
    e.a_oe  = !oe_ba_n;
    e.b_out = le_ab ? a_in : m_ab;
    e.a_out = le_ba ? b_in : m_ba;
    e.req   = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (b_oe !== e.b_oe || a_oe !== e.a_oe) begin
        miscompares++;
        $display("FAIL %s: enables a_oe=%b b_oe=%b, expected a_oe=%b b_oe=%b",
                 e.req, a_oe, b_oe, e.a_oe, e.b_oe);
      end else if (e.b_oe && b_out !== e.b_out) begin
        miscompares++;
        $display("FAIL %s: b_out=%h expected %h", e.req, b_out, e.b_out);
      end else if (e.a_oe && a_out !== e.a_out) begin
        miscompares++;
        $display("FAIL %s: a_out=%h expected %h", e.req, a_out, e.a_out);
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R8 reset clears both stores; only A-to-B drives
    tick("R8"); tick("R8");
    rst_n = 1'b1;
    // R3 transparent, clock stopped: output follows input with no edge
    run_ab = 1'b0; le_ab = 1'b1;
    a_in = 18'h2A5A5; tick("R3");
    a_in = 18'h15A5A; tick("R3");
    // R1 non-inverting all ones / all zeros
    a_in = 18'h3FFFF; tick("R1");
    a_in = 18'h00000; tick("R1");
    // R7 tracking while clocked, then latch-enable falls with ce high
    run_ab = 1'b1; a_in = 18'h3C3C3; tick("R7");
    le_ab = 1'b0; ce_ab_n = 1'b1; a_in = 18'h00FFF; tick("R7");
    // R4 clocked capture
    ce_ab_n = 1'b0; a_in = 18'h12345; tick("R4");
    // R6 ce high, edges keep arriving
    ce_ab_n = 1'b1; a_in = 18'h3FFFF; tick("R6");
    a_in = 18'h0F0F0; tick("R6"); tick("R6");
    // R5 clock held low, ce low, input changes
    run_ab = 1'b0; ce_ab_n = 1'b0; a_in = 18'h00001; tick("R5");
    a_in = 18'h2AAAA; tick("R5");
    // R2 output disabled for both directions under several control mixes
    oe_ab_n = 1'b1; le_ab = 1'b1; tick("R2");
    run_ab = 1'b1; le_ab = 1'b0; ce_ab_n = 1'b1; tick("R2");
    // R9 B-to-A direction, A disabled (R10: never both enabled)
    oe_ba_n = 1'b0;
    run_ba = 1'b0; le_ba = 1'b1; b_in = 18'h1B2C3; tick("R9");
    b_in = 18'h2D4E5; tick("R9");
    run_ba = 1'b1; b_in = 18'h31337; tick("R9");
    le_ba = 1'b0; b_in = 18'h00042; tick("R9");
    ce_ba_n = 1'b0; b_in = 18'h0ABCD; tick("R9");
    ce_ba_n = 1'b1; b_in = 18'h3FFFF; tick("R9"); tick("R9");
    run_ba = 1'b0; ce_ba_n = 1'b0; b_in = 18'h11111; tick("R9");
    // R9 independence: A store still holds 12345 after B activity, A clock ran with ce high
    oe_ba_n = 1'b1; tick("R10");
    oe_ab_n = 1'b0; tick("R9");
    // R8 reset on A only (B clock stopped keeps its word)
    rst_n = 1'b0; tick("R8");
    rst_n = 1'b1; oe_ab_n = 1'b1; tick("R8");
    oe_ba_n = 1'b0; tick("R8");
    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule